// File: doc/BRIEF.md
# Byte FIFO Pair with Level Thresholds and Timed Flush

This block sits between a register interface and a serial bus engine and buffers bytes in both directions. The register side pushes bytes into the transmit FIFO and the engine drains them; the engine pushes received bytes into the receive FIFO and the register side drains them. Each FIFO has a depth set by a parameter and a small threshold register. The block reports level flags: empty, nearly-empty, full and a sticky overrun flag for transmit, and empty, nearly-full and full for receive.

Either FIFO can be flushed by a one-cycle request. The flush is not instant. The FIFO is cleared on the clock edge that samples the request. A busy flag then stays high for a fixed number of cycles, and software polls it until it drops. While busy, traffic on that FIFO is ignored. Threshold writes are clamped so that no threshold exceeds half the depth minus one.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty with count 0, both busy flags and the overrun flag are low, and both thresholds read 0.
- R2: Bytes leave each FIFO in the order they were pushed. The head output shows the oldest byte, or 0 when the FIFO is empty. A pop removes the head at the clock edge, and the count follows pushes and pops.
- R3: The transmit FIFO reports full at DEPTH (16) entries. A push while full is discarded, and the stored bytes and their order do not change.
- R4: A push to a full transmit FIFO sets the overrun flag. The flag stays set until a transmit flush request is accepted, which clears it.
- R5: Transmit nearly-empty is high exactly when the transmit count is less than or equal to the transmit threshold.
- R6: Receive nearly-full is high exactly when the receive count is greater than or equal to the receive threshold. Receive full is high at DEPTH entries.
- R7: A threshold-load strobe captures both threshold inputs. Each value is clamped to DEPTH/2-1 (7 for depth 16), and the captured values appear on the threshold outputs.
- R8: An accepted flush request clears that FIFO's count and pointers on the edge that samples it. Its busy flag is then high for exactly FLUSH_CYC (4) cycles, starting in the cycle after that edge, and then goes low.
- R9: While a FIFO's busy flag is high, pushes and pops on it are ignored and a further flush request is ignored. The other FIFO is not affected.
- R10: A pop from an empty receive FIFO has no effect, and its head output reads 0.
- R11: A pop from an empty transmit FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_load | input | 1 | Capture both threshold inputs (clamped) |
| tx_thr_d | input | THR_W | Requested transmit threshold |
| rx_thr_d | input | THR_W | Requested receive threshold |
| tx_thr | output | THR_W | Effective transmit threshold |
| rx_thr | output | THR_W | Effective receive threshold |
| flush_tx_req | input | 1 | Request a transmit flush |
| flush_rx_req | input | 1 | Request a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress |
| flush_rx_busy | output | 1 | Receive flush in progress |
| tx_push | input | 1 | Register side writes a transmit byte |
| tx_wdata | input | DW | Transmit byte to store |
| tx_pop | input | 1 | Engine consumes the transmit head |
| tx_head | output | DW | Oldest transmit byte, 0 when empty |
| tx_count | output | CNT_W | Transmit entries held |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_near_empty | output | 1 | Transmit count at or below threshold |
| tx_full | output | 1 | Transmit FIFO full |
| tx_overrun | output | 1 | Sticky: push to a full transmit FIFO |
| rx_push | input | 1 | Engine stores a received byte |
| rx_wdata | input | DW | Received byte to store |
| rx_pop | input | 1 | Register side reads the receive head |
| rx_head | output | DW | Oldest received byte, 0 when empty |
| rx_count | output | CNT_W | Receive entries held |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_near_full | output | 1 | Receive count at or above threshold |
| rx_full | output | 1 | Receive FIFO full |

## Verification
The assertions assume that a flush request and a push never target the same FIFO in the same cycle unless the request is meant to win. They also assume reset is applied before any traffic, and that the push-while-full checks are read with a concurrent pop allowed. The stimulus drives every input at the falling edge and one operation at a time. It issues flush requests as single-cycle pulses, except where a second request during busy is the point of the test. It never loads a threshold in the same cycle as a push or pop, so each level flag can be predicted from the count alone.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

   // largest threshold a FIFO of the given depth accepts, also limited by the register width
   function automatic int thr_limit(input int depth, input int thr_w);
      int half_lim;
      int reg_lim;
      half_lim = depth / 2 - 1;
      reg_lim  = (1 << thr_w) - 1;
      return (half_lim < reg_lim) ? half_lim : reg_lim;
   endfunction

   localparam int CH_TX = 0;
   localparam int CH_RX = 1;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       hold,
   input  logic                       push,
   input  logic [DW-1:0]              wdata,
   input  logic                       pop,
   output logic [DW-1:0]              head,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full && !clr && !hold;
   assign do_pop  = pop && !empty && !clr && !hold;
   assign count   = cnt_q;
   assign head    = empty ? '0 : mem[rptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= wdata;
   end

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0) && (wptr_q == '0) && (rptr_q == '0));
   assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> ($stable(wptr_q) && $stable(rptr_q) && $stable(cnt_q)));
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> $stable(wptr_q));
   assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> $stable(rptr_q));

endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic start,
   output logic busy
);
   assign start = req && !busy;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("flush_seq: CYCLES must be at least 1");
      end
      if (CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy <= 1'b0;
            else        busy <= start;
         end
      end else begin : g_counter
         localparam int LW = $clog2(CYCLES + 1);
         logic [LW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             left_q <= '0;
            else if (start)         left_q <= LW'(CYCLES);
            else if (left_q != '0)  left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate

   // run length of the busy window, kept only for the length check
   logic [15:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   assert_busy_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == 16'(CYCLES)));
   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && busy) |-> !start);

endmodule

// File: rtl/thr_reg.sv
module thr_reg #(
   parameter int THR_W = 4,
   parameter int MAXV  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [THR_W-1:0] d,
   output logic [THR_W-1:0] q
);
   localparam logic [THR_W-1:0] MAXQ = THR_W'(MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= (d > MAXQ) ? MAXQ : d;
   end

   assert_thr_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q <= MAXQ);
   assert_thr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int THR_W     = 4,
   parameter int FLUSH_CYC = 4,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_load,
   input  logic [THR_W-1:0] tx_thr_d,
   input  logic [THR_W-1:0] rx_thr_d,
   output logic [THR_W-1:0] tx_thr,
   output logic [THR_W-1:0] rx_thr,
   input  logic             flush_tx_req,
   input  logic             flush_rx_req,
   output logic             flush_tx_busy,
   output logic             flush_rx_busy,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_wdata,
   input  logic             tx_pop,
   output logic [DW-1:0]    tx_head,
   output logic [CNT_W-1:0] tx_count,
   output logic             tx_empty,
   output logic             tx_near_empty,
   output logic             tx_full,
   output logic             tx_overrun,
   input  logic             rx_push,
   input  logic [DW-1:0]    rx_wdata,
   input  logic             rx_pop,
   output logic [DW-1:0]    rx_head,
   output logic [CNT_W-1:0] rx_count,
   output logic             rx_empty,
   output logic             rx_near_full,
   output logic             rx_full
);
   import xfp_pkg::*;

   localparam int THR_MAX = thr_limit(DEPTH, THR_W);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("xfer_fifo_pair: DEPTH must be a power of two, at least 4");
      end
      if (THR_W < 1 || DW < 1) begin : g_bad_width
         $error("xfer_fifo_pair: widths must be positive");
      end
   endgenerate

   // channel-indexed views: index CH_TX and CH_RX
   logic             ch_req   [2];
   logic             ch_start [2];
   logic             ch_busy  [2];
   logic             ch_push  [2];
   logic             ch_pop   [2];
   logic [DW-1:0]    ch_wdata [2];
   logic [DW-1:0]    ch_head  [2];
   logic [CNT_W-1:0] ch_count [2];
   logic             ch_full  [2];
   logic             ch_empty [2];
   logic [THR_W-1:0] ch_thr_d [2];
   logic [THR_W-1:0] ch_thr   [2];

   assign ch_req[CH_TX]   = flush_tx_req;
   assign ch_req[CH_RX]   = flush_rx_req;
   assign ch_push[CH_TX]  = tx_push;
   assign ch_push[CH_RX]  = rx_push;
   assign ch_pop[CH_TX]   = tx_pop;
   assign ch_pop[CH_RX]   = rx_pop;
   assign ch_wdata[CH_TX] = tx_wdata;
   assign ch_wdata[CH_RX] = rx_wdata;
   assign ch_thr_d[CH_TX] = tx_thr_d;
   assign ch_thr_d[CH_RX] = rx_thr_d;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      flush_seq #(.CYCLES(FLUSH_CYC)) u_flush (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (ch_req[c]),
         .start (ch_start[c]),
         .busy  (ch_busy[c])
      );

      fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (ch_start[c]),
         .hold  (ch_busy[c]),
         .push  (ch_push[c]),
         .wdata (ch_wdata[c]),
         .pop   (ch_pop[c]),
         .head  (ch_head[c]),
         .count (ch_count[c]),
         .full  (ch_full[c]),
         .empty (ch_empty[c])
      );

      thr_reg #(.THR_W(THR_W), .MAXV(THR_MAX)) u_thr (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (thr_load),
         .d     (ch_thr_d[c]),
         .q     (ch_thr[c])
      );
   end

   // sticky transmit overrun, cleared by an accepted transmit flush
   logic ovr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (ch_start[CH_TX])
         ovr_q <= 1'b0;
      else if (tx_push && ch_full[CH_TX] && !ch_busy[CH_TX])
         ovr_q <= 1'b1;
   end

   assign tx_thr        = ch_thr[CH_TX];
   assign rx_thr        = ch_thr[CH_RX];
   assign flush_tx_busy = ch_busy[CH_TX];
   assign flush_rx_busy = ch_busy[CH_RX];
   assign tx_head       = ch_head[CH_TX];
   assign tx_count      = ch_count[CH_TX];
   assign tx_empty      = ch_empty[CH_TX];
   assign tx_full       = ch_full[CH_TX];
   assign tx_overrun    = ovr_q;
   assign tx_near_empty = (32'(ch_count[CH_TX]) <= 32'(ch_thr[CH_TX]));
   assign rx_head       = ch_head[CH_RX];
   assign rx_count      = ch_count[CH_RX];
   assign rx_empty      = ch_empty[CH_RX];
   assign rx_full       = ch_full[CH_RX];
   assign rx_near_full  = (32'(ch_count[CH_RX]) >= 32'(ch_thr[CH_RX]));

   assert_ovr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_full && !flush_tx_busy && !flush_tx_req) |=> tx_overrun);
   assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_overrun && !flush_tx_req) |=> tx_overrun);
   assert_ovr_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_tx_req && !flush_tx_busy) |=> !tx_overrun);
   assert_tx_flush_spares_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_tx_busy && !rx_push && !rx_pop && !flush_rx_req && !flush_rx_busy)
      |=> $stable(rx_count));
   assert_empty_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && !rx_push) |=> (rx_head == '0));

endmodule

// File: tb/sim_xfer_fifo_pair.sv
module sim_xfer_fifo_pair;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int THR_W = 4;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             thr_load = 1'b0;
   logic [THR_W-1:0] tx_thr_d = '0, rx_thr_d = '0;
   logic [THR_W-1:0] tx_thr, rx_thr;
   logic             flush_tx_req = 1'b0, flush_rx_req = 1'b0;
   logic             flush_tx_busy, flush_rx_busy;
   logic             tx_push = 1'b0, tx_pop = 1'b0;
   logic [DW-1:0]    tx_wdata = '0;
   logic [DW-1:0]    tx_head;
   logic [CNT_W-1:0] tx_count;
   logic             tx_empty, tx_near_empty, tx_full, tx_overrun;
   logic             rx_push = 1'b0, rx_pop = 1'b0;
   logic [DW-1:0]    rx_wdata = '0;
   logic [DW-1:0]    rx_head;
   logic [CNT_W-1:0] rx_count;
   logic             rx_empty, rx_near_full, rx_full;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   xfer_fifo_pair #(.DEPTH(DEPTH), .DW(DW), .THR_W(THR_W), .FLUSH_CYC(4)) u0 (
      .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .tx_thr_d(tx_thr_d),
      .rx_thr_d(rx_thr_d), .tx_thr(tx_thr), .rx_thr(rx_thr),
      .flush_tx_req(flush_tx_req), .flush_rx_req(flush_rx_req),
      .flush_tx_busy(flush_tx_busy), .flush_rx_busy(flush_rx_busy),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_head(tx_head),
      .tx_count(tx_count), .tx_empty(tx_empty), .tx_near_empty(tx_near_empty),
      .tx_full(tx_full), .tx_overrun(tx_overrun),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_head(rx_head),
      .rx_count(rx_count), .rx_empty(rx_empty), .rx_near_full(rx_near_full),
      .rx_full(rx_full)
   );

   // op codes: 0 transmit push, 1 transmit pop, 2 receive push, 3 receive pop
   typedef struct packed {
      logic [1:0] op;
      logic [7:0] data;
      logic [4:0] exp_cnt;
      logic [7:0] exp_head;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{2'd0, 8'hA1, 5'd1, 8'hA1},
      '{2'd0, 8'hB2, 5'd2, 8'hA1},
      '{2'd0, 8'hC3, 5'd3, 8'hA1},
      '{2'd1, 8'h00, 5'd2, 8'hB2},
      '{2'd2, 8'h11, 5'd1, 8'h11},
      '{2'd1, 8'h00, 5'd1, 8'hC3},
      '{2'd2, 8'h22, 5'd2, 8'h11},
      '{2'd3, 8'h00, 5'd1, 8'h22},
      '{2'd1, 8'h00, 5'd0, 8'h00},
      '{2'd3, 8'h00, 5'd0, 8'h00},
      '{2'd3, 8'h00, 5'd0, 8'h00},
      '{2'd1, 8'h00, 5'd0, 8'h00}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int op, input logic [7:0] d);
      @(negedge clk);
      case (op)
         0: begin tx_push = 1'b1; tx_wdata = d; end
         1: tx_pop = 1'b1;
         2: begin rx_push = 1'b1; rx_wdata = d; end
         default: rx_pop = 1'b1;
      endcase
      @(negedge clk);
      tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
   endtask

   task automatic load_thr(input logic [3:0] t, input logic [3:0] r);
      @(negedge clk);
      thr_load = 1'b1; tx_thr_d = t; rx_thr_d = r;
      @(negedge clk);
      thr_load = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 tx_count", tx_count, 0);
      chk("R1 rx_count", rx_count, 0);
      chk("R1 busy", {flush_tx_busy, flush_rx_busy}, 0);
      chk("R1 overrun", tx_overrun, 0);
      chk("R1 thresholds", {tx_thr, rx_thr}, 0);

      // R2 R10 R11 table walk
      for (int i = 0; i < 12; i++) begin
         step(int'(VECS[i].op), VECS[i].data);
         if (VECS[i].op < 2) begin
            chk($sformatf("R2 vec%0d tx_count", i), tx_count, VECS[i].exp_cnt);
            chk($sformatf("R2 R11 vec%0d tx_head", i), tx_head, VECS[i].exp_head);
         end else begin
            chk($sformatf("R2 vec%0d rx_count", i), rx_count, VECS[i].exp_cnt);
            chk($sformatf("R2 R10 vec%0d rx_head", i), rx_head, VECS[i].exp_head);
         end
      end

      // R3 R4 fill, overfill, drain in order
      for (int i = 0; i < DEPTH; i++) step(0, 8'h40 + 8'(i));
      chk("R3 tx_full", tx_full, 1);
      chk("R3 tx_count", tx_count, DEPTH);
      chk("R5 near_empty at full thr0", tx_near_empty, 0);
      chk("R4 overrun before", tx_overrun, 0);
      step(0, 8'h5A);
      chk("R3 count after overfill", tx_count, DEPTH);
      chk("R4 overrun set", tx_overrun, 1);
      repeat (3) @(negedge clk);
      chk("R4 overrun sticky", tx_overrun, 1);
      for (int i = 0; i < DEPTH; i++) begin
         chk($sformatf("R3 drain head %0d", i), tx_head, 8'h40 + i);
         step(1, 8'h00);
      end
      chk("R3 drained", tx_empty, 1);
      chk("R4 overrun after drain", tx_overrun, 1);

      // R8 R4 flush timing and overrun clear
      @(negedge clk);
      flush_tx_req = 1'b1;
      @(negedge clk);
      flush_tx_req = 1'b0;
      n = 0;
      while (flush_tx_busy && n < 20) begin n++; @(negedge clk); end
      chk("R8 tx busy cycles", n, 4);
      chk("R4 overrun cleared by flush", tx_overrun, 0);

      // R7 clamp
      load_thr(4'd15, 4'd3);
      chk("R7 tx clamp", tx_thr, 7);
      chk("R7 rx load", rx_thr, 3);

      // R5 nearly-empty boundary
      for (int i = 0; i < 7; i++) step(0, 8'(i));
      chk("R5 count7 thr7", tx_near_empty, 1);
      step(0, 8'h07);
      chk("R5 count8 thr7", tx_near_empty, 0);

      // R6 nearly-full boundary
      step(2, 8'h01);
      step(2, 8'h02);
      chk("R6 rx count2 thr3", rx_near_full, 0);
      step(2, 8'h03);
      chk("R6 rx count3 thr3", rx_near_full, 1);

      // R8 R9 transmit flush with a push during busy; receive untouched
      @(negedge clk);
      flush_tx_req = 1'b1;
      @(negedge clk);
      flush_tx_req = 1'b0;
      chk("R8 tx count cleared", tx_count, 0);
      n = 1;
      tx_push = 1'b1; tx_wdata = 8'hEE;
      @(negedge clk);
      tx_push = 1'b0;
      while (flush_tx_busy && n < 20) begin n++; @(negedge clk); end
      chk("R8 tx busy cycles 2", n, 4);
      chk("R9 push during busy ignored", tx_count, 0);
      chk("R9 rx unaffected", rx_count, 3);

      // R6 receive full
      for (int i = 0; i < DEPTH - 3; i++) step(2, 8'h80 + 8'(i));
      chk("R6 rx_full", rx_full, 1);

      // R9 receive flush: pop and second request during busy ignored
      @(negedge clk);
      flush_rx_req = 1'b1;
      @(negedge clk);
      flush_rx_req = 1'b0;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      flush_rx_req = 1'b1;
      n = 2;
      chk("R9 rx busy mid", flush_rx_busy, 1);
      @(negedge clk);
      flush_rx_req = 1'b0;
      while (flush_rx_busy && n < 20) begin n++; @(negedge clk); end
      chk("R9 rx busy not extended", n, 4);
      chk("R8 rx count cleared", rx_count, 0);
      chk("R10 rx head empty", rx_head, 0);

      // R7 second load, in range and above range
      load_thr(4'd5, 4'd9);
      chk("R7 tx in range", tx_thr, 5);
      chk("R7 rx clamp", rx_thr, 7);

      summary();
   end
endmodule